// File: doc/BRIEF.md
# PHY Event Interrupt Collector

This block gathers single-cycle event pulses from a PHY's link and receive logic and holds each one in a status word until software reads it. A mask word decides which events are recorded at all. The mask word also carries a global enable for the interrupt pin. While any recorded event is still enabled and the pin is enabled, the block pulls an active-low interrupt line. Software reaches both words through a small register port with one request per cycle. A read returns its data one cycle later. Reading the status word empties it.

The pin is driven by a two-state machine. The machine sits in `PIN_IDLE` with the line high. The transition *raise* moves it to `PIN_ASSERT` (line low) on the clock edge after a pending, enabled event is present while the enable is 1. The transition *drop* returns it to `PIN_IDLE` on the clock edge after that condition goes away, whether a read cleared the status or a mask write removed it. In any other case the machine holds its state.

Top module: `phy_irq_unit`

## Requirements
- R1: After reset the mask word and status word both read 0, `irq_n` is 1 and `rd_valid` is 0.
- R2: The mask word (address 0) stores only bits 15, 13, 11, 10, 8 and 7 of a write. Every other bit of either word reads as 0, so writing 0xFFFF to the mask reads back 0xAD80. The mask holds its value until the next write to address 0.
- R3: Each event has a fixed status bit: link change sets bit 13, negotiation error sets bit 11, negotiation complete sets bit 10, symbol error sets bit 8 and loss of descrambler lock sets bit 7. A pulse in cycle n sets the bit from edge n onward, provided the mask bit at the same position is 1.
- R4: An event whose mask bit is 0 leaves the status word unchanged.
- R5: A read of the status word (address 1) returns its content and clears every bit. A second read with no new event returns 0.
- R6: An event that arrives in the same cycle as a status read is absent from that read and present in the next one.
- R7: Status bit 15 reads 1 exactly when some status event bit is set whose mask bit is currently 1.
- R8: `irq_n` goes low one cycle after the status word holds an event with its mask bit set while mask bit 15 is 1. It returns high one cycle after that condition ends. It stays high while mask bit 15 is 0.
- R9: Writes to address 1 have no effect on the status word.
- R10: A read request in cycle n gives `rd_valid` = 1 with `rd_data` in cycle n+1 only; writes never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_link_chg | input | 1 | Link state change pulse |
| ev_aneg_err | input | 1 | Auto-negotiation error pulse |
| ev_aneg_done | input | 1 | Auto-negotiation complete pulse |
| ev_sym_err | input | 1 | Symbol error pulse |
| ev_lock_lost | input | 1 | Descrambler lock loss pulse |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = mask word, 1 = status word |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Suppose a status bit is latched without its mask bit, or is not cleared by a read. Then the next status read returns a word that differs from the one the bench expects, one cycle after that read. If a same-cycle event is dropped, the read that follows shows 0 where the event bit should be. If the pin machine is stuck or lags, `irq_n` has the wrong level two cycles after the event pulse, or two cycles after the clearing read or the mask write. If the mask storage is wrong, the mask read-back shows it at once, and the mapping of each event to its status bit then goes wrong as well.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int DATA_W  = 16;
    localparam int EV_NUM  = 5;
    localparam int SUM_BIT = 15;

    // event index -> status/mask bit position
    // index 0 link change, 1 neg. error, 2 neg. done, 3 symbol error, 4 lock loss
    localparam int EV_BIT [EV_NUM] = '{13, 11, 10, 8, 7};

    typedef enum logic {
        PIN_IDLE   = 1'b0,
        PIN_ASSERT = 1'b1
    } pin_state_e;

    function automatic logic [DATA_W-1:0] ev_field();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < EV_NUM; i++) begin
            m[EV_BIT[i]] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] EV_FIELD = ev_field();
    localparam logic [DATA_W-1:0] WR_FIELD = EV_FIELD | (DATA_W'(1) << SUM_BIT);

endpackage

// File: rtl/phy_irq_mask_reg.sv
module phy_irq_mask_reg
    import phy_irq_pkg::*;
#(
    parameter int                W       = DATA_W,
    parameter logic [W-1:0]      KEEP    = WR_FIELD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wdata & KEEP;
        end
    end

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(mask_q));

endmodule

// File: rtl/phy_irq_status_reg.sv
module phy_irq_status_reg
    import phy_irq_pkg::*;
#(
    parameter int N = EV_NUM
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic [N-1:0] ev_en_i,
    input  logic         rd_clr_i,
    output logic [N-1:0] stat_q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic set_w;
        assign set_w = ev_i[g] & ev_en_i[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[g] <= 1'b0;
            end else if (rd_clr_i) begin
                stat_q[g] <= set_w;
            end else if (set_w) begin
                stat_q[g] <= 1'b1;
            end
        end

        // R3 R4
        set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_q[g]) |-> $past(ev_i[g] && ev_en_i[g]));

        // R5
        clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_clr_i && !ev_i[g]) |-> !stat_q[g]);

        // R6
        keep_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_clr_i && ev_i[g] && ev_en_i[g]) |-> stat_q[g]);
    end

endmodule

// File: rtl/phy_irq_pin_fsm.sv
module phy_irq_pin_fsm
    import phy_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_en_i,
    input  logic pending_i,
    output logic irq_n
);

    pin_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE:   if (pin_en_i && pending_i)    state_d = PIN_ASSERT;
            PIN_ASSERT: if (!(pin_en_i && pending_i)) state_d = PIN_IDLE;
            default:    state_d = PIN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PIN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_n = 1'b1;
        unique case (state_q)
            PIN_IDLE:   irq_n = 1'b1;
            PIN_ASSERT: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end

    // R8
    pin_low_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(pin_en_i && pending_i));

    // R8
    pin_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pin_en_i && pending_i) |-> !irq_n);

endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
    import phy_irq_pkg::*;
#(
    parameter int                ADDR_W    = 1,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 1'b0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_link_chg,
    input  logic              ev_aneg_err,
    input  logic              ev_aneg_done,
    input  logic              ev_sym_err,
    input  logic              ev_lock_lost,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);

    localparam logic [DATA_W-1:0] RSVD = ~WR_FIELD;

    logic [EV_NUM-1:0] ev_vec, ev_en, stat_vec;
    logic [DATA_W-1:0] mask_q, stat_word;
    logic              mask_wr, stat_rd, pending;

    assign ev_vec  = {ev_lock_lost, ev_sym_err, ev_aneg_done, ev_aneg_err, ev_link_chg};
    assign mask_wr = req_valid && req_write && (req_addr == MASK_ADDR);
    assign stat_rd = req_valid && !req_write && (req_addr == STAT_ADDR);

    phy_irq_mask_reg #(.W(DATA_W), .KEEP(WR_FIELD)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mask_wr),
        .wdata  (req_wdata),
        .mask_q (mask_q)
    );

    for (genvar g = 0; g < EV_NUM; g++) begin : g_en
        assign ev_en[g] = mask_q[EV_BIT[g]];
    end

    phy_irq_status_reg #(.N(EV_NUM)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev_vec),
        .ev_en_i  (ev_en),
        .rd_clr_i (stat_rd),
        .stat_q   (stat_vec)
    );

    assign pending = |(stat_vec & ev_en);

    always_comb begin
        stat_word = '0;
        for (int i = 0; i < EV_NUM; i++) begin
            stat_word[EV_BIT[i]] = stat_vec[i];
        end
        stat_word[SUM_BIT] = pending;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                if (req_addr == MASK_ADDR)      rd_data <= mask_q;
                else if (req_addr == STAT_ADDR) rd_data <= stat_word;
                else                            rd_data <= '0;
            end
        end
    end

    phy_irq_pin_fsm u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_en_i  (mask_q[SUM_BIT]),
        .pending_i (pending),
        .irq_n     (irq_n)
    );

    // R10
    rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & RSVD) == '0));

    // R7
    summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_addr == STAT_ADDR))
            |-> (rd_data[SUM_BIT] == |(rd_data & $past(mask_q) & EV_FIELD)));

endmodule

// File: tb/test_phy_irq_unit.sv
module test_phy_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ev = '0;   // [0] link [1] neg err [2] neg done [3] sym [4] lock
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [0:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid, irq_n;
    logic [15:0] rd_data;

    always #4 clk = ~clk;

    phy_irq_unit i_phy_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .ev_link_chg(ev[0]), .ev_aneg_err(ev[1]), .ev_aneg_done(ev[2]),
        .ev_sym_err(ev[3]), .ev_lock_lost(ev[4]),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .irq_n(irq_n)
    );

    typedef struct { logic [15:0] exp; string tag; } sb_item_t;
    sb_item_t sb_q[$];
    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic a,
                         input logic [15:0] d, input logic [4:0] e);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; ev = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 16'h0, 5'b0);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        drive(1, 1, a, d, 5'b0);
    endtask

    task automatic rd_ev(input logic a, input logic [15:0] exp, input string tag,
                         input logic [4:0] e);
        sb_q.push_back('{exp: exp, tag: tag});
        drive(1, 0, a, 16'h0, e);
    endtask

    task automatic rd(input logic a, input logic [15:0] exp, input string tag);
        rd_ev(a, exp, tag, 5'b0);
    endtask

    task automatic pulse(input logic [4:0] e);
        drive(0, 0, 0, 16'h0, e);
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R10 act=%h exp=none (unexpected rd_valid)", rd_data);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                chk(it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq_n", {15'h0, irq_n}, 16'h1);
        chk("R1 rd_valid", {15'h0, rd_valid}, 16'h0);
        rd(0, 16'h0000, "R1 mask");
        rd(1, 16'h0000, "R1 status");

        // R2 writable field
        wr(0, 16'hFFFF);
        rd(0, 16'hAD80, "R2 mask readback");

        // R3 R7 R8 pin disabled, R5 clear
        wr(0, 16'h2D80);
        pulse(5'b00001);
        idle(2);
        chk("R8 pin disabled", {15'h0, irq_n}, 16'h1);
        rd(1, 16'hA000, "R3 link bit13 + R7 summary");
        rd(1, 16'h0000, "R5 cleared");

        // R4 masked events ignored
        wr(0, 16'h0400);
        pulse(5'b11111);
        idle(1);
        rd(1, 16'h8400, "R4 only neg-done kept");
        idle(1);
        chk("R8 pin off with status", {15'h0, irq_n}, 16'h1);

        // R8 pin asserts / releases
        wr(0, 16'hAD80);
        pulse(5'b01000);
        idle(2);
        chk("R8 irq low", {15'h0, irq_n}, 16'h0);
        rd(1, 16'h8100, "R3 sym bit8");
        idle(2);
        chk("R8 irq released", {15'h0, irq_n}, 16'h1);

        // R3 several events together
        pulse(5'b10110);
        idle(2);
        chk("R8 irq low multi", {15'h0, irq_n}, 16'h0);
        rd(1, 16'h8C80, "R3 err/done/lock");
        idle(2);
        chk("R8 irq released multi", {15'h0, irq_n}, 16'h1);

        // R9 status writes ignored
        pulse(5'b00001);
        wr(1, 16'h0000);
        wr(1, 16'hFFFF);
        rd(1, 16'hA000, "R9 status unchanged");

        // R6 event during read
        pulse(5'b10000);
        rd_ev(1, 16'h8080, "R6 read before event", 5'b01000);
        rd(1, 16'h8100, "R6 event kept");

        // R7 summary follows current mask
        pulse(5'b00001);
        idle(2);
        chk("R8 irq low link", {15'h0, irq_n}, 16'h0);
        wr(0, 16'h8000);
        idle(2);
        chk("R8 irq drops on mask", {15'h0, irq_n}, 16'h1);
        rd(1, 16'h2000, "R7 summary off");
        rd(0, 16'h8000, "R2 mask value");

        // R10 read timing
        rd(0, 16'h8000, "R10 data");
        idle(1);
        chk("R10 valid n+1", {15'h0, rd_valid}, 16'h1);
        idle(1);
        chk("R10 valid n+2", {15'h0, rd_valid}, 16'h0);
        wr(0, 16'h0000);
        idle(1);
        chk("R10 no valid on write", {15'h0, rd_valid}, 16'h0);
        idle(2);
        chk("R10 all reads returned", 16'(sb_q.size()), 16'h0);

        done = 1'b1;
        finish_run();
    end

endmodule